// File: doc/BRIEF.md
# Synchronous Half-Duplex Serial Shifter

This block is a byte-wide synchronous serial port that always acts as clock master. A single data line carries bits in either direction, split into an input, an output and an output enable at the block edge, and a separate line carries the shift clock. All activity is paced by a machine-cycle sequencer. One machine cycle lasts 12 clocks and is divided into six states of two phases each. Every shift, sample and flag event falls in a fixed slot of that cycle, and one bit moves per machine cycle.

The host starts a transmit by pulsing a write strobe with a byte. It starts a receive by holding receive enable high while the receive-done flag is clear. Completion is not counted. A marker bit loaded next to the data travels through the shift register, and its arrival at the far end triggers one final shift. The done flags then rise at the start of a machine cycle and stay set until the host clears them.

Top module: `sync_shift_port`

## Requirements
- R1: The sequencer steps through slot indices 0 to 11, one per clock. Slot S1P1 is index 0, and index = 2*(state-1) + (phase-1), so S3P1 is 4, S5P2 is 9 and S6P2 is 11. Synchronous reset restarts it at index 0.
- R2: While no transfer is active, `sclk` is 1. While a transmit or receive is active, `sclk` is 0 exactly in slots 4 to 9 (states S3 to S5) and 1 in all other slots. A full transfer gives 8 low pulses.
- R3: A transmit write is taken into a 9-bit register with a 1 above the byte. The load happens at the first S6P2 clock edge at or after the write clock. The first clock edge after the load moves the sequencer to S1P1.
- R4: The transfer becomes active one machine cycle after the load. `sd_oe` is 1 only while it is active. The data bits appear on `sd_out` least significant bit first, each one present at a rising edge of `sclk` and changing only at S6P2 shifts.
- R5: `tx_done` becomes 1 exactly 109 clocks after the load edge, at the S1P1 slot. This follows the final shift made once the marker sits just above the last data bit.
- R6: A write is ignored while a transmit is pending, loaded or active. The byte already accepted is sent unchanged, and no further transfer follows.
- R7: A receive starts when `rx_en` is 1, `rx_done` is 0, no transmit is busy and `tx_wr` is 0. The receive register is preloaded one machine cycle after the first S6P2 edge that follows the start. Receive is active from the next S1P1 slot. While `rx_done` is 1, no receive starts.
- R8: During a receive, `sd_in` is sampled at S5P2 (slot 9) and shifted in at S6P2 (slot 11). The first bit received becomes bit 0 of `rx_byte`. `rx_byte` changes only when the final shift copies the completed byte.
- R9: `rx_done` becomes 1 exactly 109 clocks after the first S6P2 edge that follows the receive start.
- R10: `tx_done` and `rx_done` stay 1 until `clr_tx_done` or `clr_rx_done` is pulsed. A clear pulse returns the flag to 0 on the next clock.
- R11: Transmit and receive never run together. When a write and a receive start arrive in the same clock, the transmit goes first and the receive starts after it ends.
- R12: Synchronous reset clears both flags and `rx_byte`, sets `sd_oe` to 0 and `sclk` to 1, and aborts any transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one sequencer slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| tx_wr | input | 1 | Transmit write strobe |
| tx_data | input | DATA_W | Byte to transmit |
| rx_en | input | 1 | Receive enable |
| clr_tx_done | input | 1 | Clears the transmit-done flag |
| clr_rx_done | input | 1 | Clears the receive-done flag |
| sd_in | input | 1 | Serial data line, input side |
| sd_out | output | 1 | Serial data line, output side |
| sd_oe | output | 1 | Data line drive enable; the line is released while 0 |
| sclk | output | 1 | Shift clock |
| tx_done | output | 1 | Transmit-done flag |
| rx_done | output | 1 | Receive-done flag |
| rx_byte | output | DATA_W | Last received byte |

## Verification
The assertions check the following on every cycle:
- The shift clock is low only inside the S3 to S5 window.
- The drive enable and the output bit change only at the shift slot or at the S1P1 release.
- Both flags rise only one slot after S1P1 and stay set until cleared.
- The received byte changes only on the final shift.
- Transmit and receive are never busy together.

Some behaviour only the bench scenarios can show. These are the exact 109-clock latencies for each write alignment and the bit order on the line for varied byte patterns. They also include the discarding of writes made while a transfer is pending or active, the refusal to restart a receive while its flag is set, the tie between write and receive start, and a reset in the middle of a transfer.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int STATES = 6;
    localparam int PHASES = 2;
    localparam int SLOTS  = STATES * PHASES;
    localparam int SLOT_W = $clog2(SLOTS);

    localparam logic [SLOT_W-1:0] SL_S1P1 = SLOT_W'(0);
    localparam logic [SLOT_W-1:0] SL_S3P1 = SLOT_W'(2 * PHASES);
    localparam logic [SLOT_W-1:0] SL_S5P2 = SLOT_W'(4 * PHASES + 1);
    localparam logic [SLOT_W-1:0] SL_S6P2 = SLOT_W'(SLOTS - 1);

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARMED = 2'd1,
        TX_SEND  = 2'd2
    } tx_st_e;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_PRE   = 2'd2,
        RX_ACT   = 2'd3
    } rx_st_e;
endpackage

// File: rtl/ssp_phase_seq.sv
module ssp_phase_seq
    import ssp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] slot_o,
    output logic              at_s1p1,
    output logic              at_s5p2,
    output logic              at_s6p2,
    output logic              low_win
);
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        if (q.slot == SL_S6P2) d.slot = SL_S1P1;
        else                   d.slot = q.slot + SLOT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign slot_o  = q.slot;
    assign at_s1p1 = (q.slot == SL_S1P1);
    assign at_s5p2 = (q.slot == SL_S5P2);
    assign at_s6p2 = (q.slot == SL_S6P2);
    assign low_win = (q.slot >= SL_S3P1) && (q.slot <= SL_S5P2);
endmodule

// File: rtl/ssp_tx_shifter.sv
module ssp_tx_shifter
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              at_s1p1,
    input  logic              at_s6p2,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inhibit,
    output logic              busy,
    output logic              send,
    output logic              bit_o,
    output logic              done_pulse
);
    localparam int SH_W = DATA_W + 1;

    typedef struct packed {
        tx_st_e            st;
        logic [SH_W-1:0]   sh;
        logic              pend;
        logic [DATA_W-1:0] hold;
        logic              last;
    } tx_t;

    localparam tx_t TX_RST = '{st: TX_IDLE, sh: '0, pend: 1'b0, hold: '0, last: 1'b0};

    tx_t  q, d;
    logic accept;
    logic marker_seen;

    always_comb begin
        d           = q;
        done_pulse  = 1'b0;
        accept      = wr && (q.st == TX_IDLE) && !q.pend && !inhibit;
        // marker 1 sits just above the final data bit, only zeros above it
        marker_seen = (q.sh[SH_W-1:2] == '0) && q.sh[1];
        case (q.st)
            TX_IDLE: begin
                if (at_s6p2 && (q.pend || accept)) begin
                    d.sh   = {1'b1, (q.pend ? q.hold : wr_data)};
                    d.pend = 1'b0;
                    d.last = 1'b0;
                    d.st   = TX_ARMED;
                end else if (accept) begin
                    d.pend = 1'b1;
                    d.hold = wr_data;
                end
            end
            TX_ARMED: begin
                if (at_s6p2) d.st = TX_SEND;
            end
            TX_SEND: begin
                if (at_s1p1 && q.last) begin
                    d.st       = TX_IDLE;
                    d.last     = 1'b0;
                    done_pulse = 1'b1;
                end else if (at_s6p2) begin
                    d.sh = {1'b0, q.sh[SH_W-1:1]};
                    if (marker_seen) d.last = 1'b1;
                end
            end
            default: d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= TX_RST;
        else     q <= d;
    end

    assign busy  = (q.st != TX_IDLE) || q.pend;
    assign send  = (q.st == TX_SEND);
    assign bit_o = q.sh[0];
endmodule

// File: rtl/ssp_rx_shifter.sv
module ssp_rx_shifter
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              at_s1p1,
    input  logic              at_s5p2,
    input  logic              at_s6p2,
    input  logic              start,
    input  logic              sd_in,
    output logic              busy,
    output logic              recv,
    output logic              done_pulse,
    output logic [DATA_W-1:0] byte_o
);
    // marker 0 at the entry end, ones elsewhere
    localparam logic [DATA_W-1:0] PRELOAD = {1'b0, {(DATA_W-1){1'b1}}};

    typedef struct packed {
        rx_st_e            st;
        logic [DATA_W-1:0] sh;
        logic              samp;
        logic              last;
        logic [DATA_W-1:0] rbuf;
    } rx_t;

    localparam rx_t RX_RST = '{st: RX_IDLE, sh: '0, samp: 1'b0, last: 1'b0, rbuf: '0};

    rx_t              q, d;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        d          = q;
        done_pulse = 1'b0;
        shifted    = {q.samp, q.sh[DATA_W-1:1]};
        case (q.st)
            RX_IDLE: begin
                if (start) d.st = RX_START;
            end
            RX_START: begin
                if (at_s6p2) d.st = RX_PRE;
            end
            RX_PRE: begin
                if (at_s6p2) begin
                    d.sh   = PRELOAD;
                    d.last = 1'b0;
                    d.st   = RX_ACT;
                end
            end
            RX_ACT: begin
                if (at_s5p2) d.samp = sd_in;
                if (at_s6p2) begin
                    d.sh = shifted;
                    if (!q.sh[0]) begin
                        d.last = 1'b1;
                        d.rbuf = shifted;
                    end
                end
                if (at_s1p1 && q.last) begin
                    d.st       = RX_IDLE;
                    d.last     = 1'b0;
                    done_pulse = 1'b1;
                end
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RX_RST;
        else     q <= d;
    end

    assign busy   = (q.st != RX_IDLE);
    assign recv   = (q.st == RX_ACT);
    assign byte_o = q.rbuf;
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_en,
    input  logic              clr_tx_done,
    input  logic              clr_rx_done,
    input  logic              sd_in,
    output logic              sd_out,
    output logic              sd_oe,
    output logic              sclk,
    output logic              tx_done,
    output logic              rx_done,
    output logic [DATA_W-1:0] rx_byte
);
    typedef struct packed {
        logic tx_done;
        logic rx_done;
    } flag_t;

    flag_t q, d;

    logic [SLOT_W-1:0] slot;
    logic at_s1p1, at_s5p2, at_s6p2, low_win;
    logic tx_busy, tx_send, tx_bit, tx_fin;
    logic rx_busy, rx_recv, rx_fin, rx_start;

    ssp_phase_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .slot_o  (slot),
        .at_s1p1 (at_s1p1),
        .at_s5p2 (at_s5p2),
        .at_s6p2 (at_s6p2),
        .low_win (low_win)
    );

    ssp_tx_shifter #(.DATA_W(DATA_W)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .at_s1p1    (at_s1p1),
        .at_s6p2    (at_s6p2),
        .wr         (tx_wr),
        .wr_data    (tx_data),
        .inhibit    (rx_busy),
        .busy       (tx_busy),
        .send       (tx_send),
        .bit_o      (tx_bit),
        .done_pulse (tx_fin)
    );

    // transmit request wins a same-clock tie with receive start
    assign rx_start = rx_en && !q.rx_done && !tx_busy && !tx_wr;

    ssp_rx_shifter #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .at_s1p1    (at_s1p1),
        .at_s5p2    (at_s5p2),
        .at_s6p2    (at_s6p2),
        .start      (rx_start),
        .sd_in      (sd_in),
        .busy       (rx_busy),
        .recv       (rx_recv),
        .done_pulse (rx_fin),
        .byte_o     (rx_byte)
    );

    always_comb begin
        d = q;
        if (tx_fin)           d.tx_done = 1'b1;
        else if (clr_tx_done) d.tx_done = 1'b0;
        if (rx_fin)           d.rx_done = 1'b1;
        else if (clr_rx_done) d.rx_done = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign tx_done = q.tx_done;
    assign rx_done = q.rx_done;
    assign sd_oe   = tx_send;
    assign sd_out  = tx_send & tx_bit;
    assign sclk    = !((tx_send || rx_recv) && low_win);
endmodule

// File: rtl/sync_shift_port_chk.sv
module sync_shift_port_chk
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              clr_tx_done,
    input logic              clr_rx_done,
    input logic              sclk,
    input logic              sd_oe,
    input logic              sd_out,
    input logic              tx_done,
    input logic              rx_done,
    input logic [DATA_W-1:0] rx_byte,
    input logic [SLOT_W-1:0] slot,
    input logic              tx_busy,
    input logic              rx_busy,
    input logic              tx_send,
    input logic              rx_recv
);
    AST_SCLK_LOW_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !sclk |-> (slot >= SL_S3P1) && (slot <= SL_S5P2)); // R2

    AST_OE_EDGE_SLOT: assert property (@(posedge clk) disable iff (rst)
        !$stable(sd_oe) |-> (slot == SL_S1P1) || (slot == SL_S1P1 + SLOT_W'(1))); // R4

    AST_TX_BIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (sd_oe && $past(sd_oe) && !$stable(sd_out)) |-> (slot == SL_S1P1)); // R4

    AST_TX_DONE_SLOT: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_done) |-> (slot == SL_S1P1 + SLOT_W'(1)) && $past(tx_send)); // R5

    AST_RX_DONE_SLOT: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_done) |-> (slot == SL_S1P1 + SLOT_W'(1)) && $past(rx_recv)); // R9

    AST_RX_BYTE_UPDATE: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_byte) |-> (slot == SL_S1P1)); // R8

    AST_TX_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (tx_done && !clr_tx_done) |=> tx_done); // R10

    AST_RX_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !clr_rx_done) |=> rx_done); // R10

    AST_HALF_DUPLEX: assert property (@(posedge clk) disable iff (rst)
        !(tx_busy && rx_busy)); // R11
endmodule

bind sync_shift_port sync_shift_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clr_tx_done (clr_tx_done),
    .clr_rx_done (clr_rx_done),
    .sclk        (sclk),
    .sd_oe       (sd_oe),
    .sd_out      (sd_out),
    .tx_done     (tx_done),
    .rx_done     (rx_done),
    .rx_byte     (rx_byte),
    .slot        (slot),
    .tx_busy     (tx_busy),
    .rx_busy     (rx_busy),
    .tx_send     (tx_send),
    .rx_recv     (rx_recv)
);

// File: tb/sync_shift_port_test.sv
module sync_shift_port_test;
    localparam int DATA_W = 8;
    localparam int NV     = 6;
    // {tx byte, rx byte, write slot}
    localparam logic [19:0] VEC [0:NV-1] = '{
        20'hA5_3C_0, 20'h01_80_B, 20'hFF_00_5,
        20'h00_FF_A, 20'h5A_C3_3, 20'h80_01_7
    };

    logic clk = 1'b0, rst = 1'b1;
    logic tx_wr = 1'b0, rx_en = 1'b0, clr_tx = 1'b0, clr_rx = 1'b0, sd_in = 1'b1;
    logic [DATA_W-1:0] tx_data = '0;
    logic sd_out, sd_oe, sclk, tx_done, rx_done;
    logic [DATA_W-1:0] rx_byte;

    sync_shift_port #(.DATA_W(DATA_W)) uut (
        .clk(clk), .rst(rst), .tx_wr(tx_wr), .tx_data(tx_data), .rx_en(rx_en),
        .clr_tx_done(clr_tx), .clr_rx_done(clr_rx), .sd_in(sd_in),
        .sd_out(sd_out), .sd_oe(sd_oe), .sclk(sclk),
        .tx_done(tx_done), .rx_done(rx_done), .rx_byte(rx_byte)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0, bslot = 0, win_err = 0;
    logic [7:0] cap = '0;
    int cap_n = 0;
    logic [7:0] rx_pat = '0;
    int rx_idx = 0;
    bit rx_drive = 1'b0;

    // independent slot model (R1)
    always @(posedge clk) begin
        if (rst) bslot <= 0;
        else     bslot <= (bslot == 11) ? 0 : bslot + 1;
    end

    always @(posedge sclk) if (sd_oe) begin
        if (cap_n < 8) cap[cap_n] = sd_out;
        cap_n++;
    end

    always @(negedge sclk) if (rx_drive && !sd_oe) begin
        if (rx_idx < 8) sd_in = rx_pat[rx_idx];
        rx_idx++;
    end

    always @(negedge clk) if (!rst && sd_oe) begin
        if (sclk !== !(bslot >= 4 && bslot <= 9)) win_err++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic align(input int s);
        do @(negedge clk); while (bslot != s);
    endtask

    task automatic run_tx(input logic [7:0] b);
        int w, cnt;
        w = bslot; cap_n = 0; cap = '0;
        tx_data = b; tx_wr = 1'b1;
        cnt = 0;
        do begin @(negedge clk); cnt++; tx_wr = 1'b0; end while (!tx_done && cnt < 400);
        chk(cnt == (11 - w) + 110, "R5 R1 R3 tx latency", cnt, (11 - w) + 110);
        chk(cap_n == 8 && cap == b, "R4 tx bits lsb first", int'(cap), int'(b));
        chk(sd_oe == 1'b0, "R4 line released after tx", int'(sd_oe), 0);
    endtask

    task automatic run_rx(input logic [7:0] b);
        int w, off, cnt;
        w = bslot; off = (w == 11) ? 12 : (11 - w);
        rx_pat = b; rx_idx = 0; rx_drive = 1'b1; rx_en = 1'b1;
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!rx_done && cnt < 400);
        rx_en = 1'b0;
        chk(cnt == off + 110, "R9 R7 rx latency", cnt, off + 110);
        chk(rx_byte == b, "R8 rx byte", int'(rx_byte), int'(b));
        chk(rx_idx == 8, "R2 rx clock pulses", rx_idx, 8);
        rx_drive = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk); clr_tx = 1'b1; clr_rx = 1'b1;
        @(negedge clk); clr_tx = 1'b0; clr_rx = 1'b0;
        chk(!tx_done && !rx_done, "R10 flags cleared", int'({tx_done, rx_done}), 0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int lows, n0;
        logic [7:0] keep;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!tx_done && !rx_done && !sd_oe && sclk && rx_byte == 0,
            "R12 reset state", int'({tx_done, rx_done, sd_oe, sclk}), 1);

        lows = 0;
        repeat (24) begin @(negedge clk); if (!sclk) lows++; end
        chk(lows == 0, "R2 idle sclk high", lows, 0);

        for (int i = 0; i < NV; i++) begin
            align(int'(VEC[i][3:0]));
            run_tx(VEC[i][19:12]);
            repeat (30) @(negedge clk);
            chk(tx_done == 1'b1, "R10 tx flag sticky", int'(tx_done), 1);
            align(int'(VEC[i][3:0]));
            run_rx(VEC[i][11:4]);
            clear_flags();
        end

        // R6: writes while pending and while sending are dropped
        align(0);
        cap_n = 0; cap = '0;
        tx_data = 8'h3C; tx_wr = 1'b1;
        @(negedge clk); tx_data = 8'h81;
        @(negedge clk); tx_wr = 1'b0;
        repeat (40) @(negedge clk);
        tx_data = 8'hC3; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
        n0 = 0;
        while (!tx_done && n0 < 400) begin @(negedge clk); n0++; end
        chk(cap_n == 8 && cap == 8'h3C, "R6 first byte kept", int'(cap), 8'h3C);
        clear_flags();
        repeat (150) @(negedge clk);
        chk(!tx_done && cap_n == 8, "R6 no extra transfer", cap_n, 8);

        // R7: no receive while rx_done is set
        align(2);
        run_rx(8'h6D);
        keep = rx_byte; n0 = rx_idx; rx_drive = 1'b1; rx_en = 1'b1;
        repeat (150) @(negedge clk);
        chk(rx_idx == n0 && rx_byte == keep && rx_done, "R7 no restart while done", rx_idx, n0);
        rx_en = 1'b0; rx_drive = 1'b0;
        clear_flags();

        // R11: write and receive start in the same clock
        align(4);
        cap_n = 0; cap = '0; rx_pat = 8'h4B; rx_idx = 0; rx_drive = 1'b1;
        tx_data = 8'h96; tx_wr = 1'b1; rx_en = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
        n0 = 0;
        while (!tx_done && n0 < 400) begin @(negedge clk); n0++; end
        chk(cap == 8'h96 && rx_idx == 0, "R11 tx first, no rx overlap", rx_idx, 0);
        n0 = 0;
        while (!rx_done && n0 < 400) begin @(negedge clk); n0++; end
        chk(rx_done && rx_byte == 8'h4B, "R11 rx after tx", int'(rx_byte), 8'h4B);
        rx_en = 1'b0; rx_drive = 1'b0;
        clear_flags();

        // R12: reset during a transmit
        align(0);
        cap_n = 0;
        tx_data = 8'h5A; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
        repeat (50) @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!sd_oe && sclk && !tx_done && rx_byte == 0, "R12 reset aborts", int'(rx_byte), 0);
        n0 = cap_n;
        repeat (150) @(negedge clk);
        chk(!tx_done && cap_n == n0, "R12 no completion after reset", int'(tx_done), 0);

        chk(win_err == 0, "R2 sclk low window", win_err, 0);
        finish_run();
    end
endmodule